// File: doc/BRIEF.md
# Paced Memory Scrub Engine

This block walks a memory range in the background. At each step it issues one read-correct-writeback request for a single line. Requests go out over a valid/ready port, and the block then waits for a completion pulse before it moves to the next line. The memory access itself and the ECC correction happen elsewhere; this block only decides when each request goes out and which line it names.

Software controls the block through one 16-bit control word:

- A 2-bit enable field turns scrubbing on or off.
- A 2-bit pace field chooses one of two fixed request intervals, fast or normal.

When the final line of the range completes, the block bumps a 2-bit pass counter. Software reads that counter back inside the same word.

Each cycle that the write strobe is high, the register-write bus delivers one control word. The range bounds are plain inputs.

Top module: `scrub_pacer`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000, `req_valid` is low, the pass count is 0 and the line pointer is at `range_lo`.
- R2: `cfg_rdata` layout: bits [1:0] hold the last written enable field, bits [3:2] hold the last written pace field, and bits [6:5] hold the pass count. Bits 4 and 15:7 read 0. Written values on bits 6:5 and on the unused bits are ignored.
- R3: Scrubbing runs only while the enable field is 2'b10. The values 2'b00, 2'b01 and 2'b11 issue no request.
- R4: A pace field of 2'b01 selects the fast interval, `FAST_IV` cycles (default 256). The values 2'b10, 2'b00 and 2'b11 select the normal interval, `SLOW_IV` cycles (default 32768). Consecutive accepted requests are one interval apart when completions return promptly.
- R5: After a write that turns scrubbing on, `req_valid` first goes high one interval after the write's clock edge.
- R6: Only one request is outstanding at a time: no new request until `cmpl_ack` has returned. The interval timer restarts at acceptance. If a completion arrives later than the interval allows, the next request comes out two cycles after the completion edge.
- R7: Requested lines run `range_lo`, `range_lo+1`, …, `range_hi`, then start again at `range_lo`.
- R8: The pass count rises by one, modulo 4, on the completion of the request for `range_hi`, and at no other time.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` holds its value.
- R10: Clearing the enable field while a request is outstanding lets that request complete and issue nothing further. The next enabling then starts again at `range_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back including pass count |
| range_lo | input | ADDR_W | First line of the scrub range |
| range_hi | input | ADDR_W | Last line of the scrub range (>= range_lo) |
| req_valid | output | 1 | Scrub request valid |
| req_ready | input | 1 | Scrub request accepted when high with valid |
| req_addr | output | ADDR_W | Line address of the scrub request |
| cmpl_ack | input | 1 | One-cycle completion of the outstanding request |

## Verification
The bench counts clock edges and derives each due cycle from that count:

- An enabling write at edge w makes `req_valid` visible just after edge w+IV.
- After that, handshakes are IV cycles apart, or D+2 cycles apart when the completion is sampled D edges after acceptance.
- A stall of S cycles on `req_ready` stretches one gap to IV+S-1.

The scoreboard queues each expected line address together with its gap. The monitor samples on the falling edge, compares the actual gap against the queued one, and treats any handshake with an empty queue as an error. Pass-count and field read-backs are taken only after the last completion has been sampled.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } scrub_st_e;

  localparam logic [1:0] RUN_CODE  = 2'b10;
  localparam logic [1:0] FAST_CODE = 2'b01;
  localparam int         CFG_W     = 16;
  localparam int         PASS_W    = 2;

  function automatic logic run_on(input logic [1:0] field);
    return field == RUN_CODE;
  endfunction

  function automatic logic pace_fast(input logic [1:0] field);
    return field == FAST_CODE;
  endfunction

endpackage

// File: rtl/scrub_ctrl_reg.sv
module scrub_ctrl_reg
  import scrub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [PASS_W-1:0] pass_cnt,
  output logic [CFG_W-1:0]  rd_data,
  output logic              run,
  output logic              fast
);

  logic [1:0] run_q, run_d;
  logic [1:0] pace_q, pace_d;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^wr_data[CFG_W-1:4];

  always_comb begin
    run_d  = run_q;
    pace_d = pace_q;
    if (wr_en) begin
      run_d  = wr_data[1:0];
      pace_d = wr_data[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 2'b00;
      pace_q <= 2'b00;
    end else if (wr_en) begin
      run_q  <= run_d;
      pace_q <= pace_d;
    end
  end

  assign rd_data = {{(CFG_W-7){1'b0}}, pass_cnt, 1'b0, pace_q, run_q};
  assign run     = run_on(run_q);
  assign fast    = pace_fast(pace_q);

endmodule

// File: rtl/scrub_pace_timer.sv
module scrub_pace_timer #(
  parameter int FAST_IV = 256,
  parameter int SLOW_IV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic restart,
  output logic due
);

  localparam int TW = $clog2(SLOW_IV + 1);
  localparam logic [TW-1:0] FAST_LIM = TW'(FAST_IV - 1);
  localparam logic [TW-1:0] SLOW_LIM = TW'(SLOW_IV - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [TW-1:0] lim;
  logic          at_lim;

  assign lim    = fast ? FAST_LIM : SLOW_LIM;
  assign at_lim = (tmr_q >= lim);

  always_comb begin
    if (!run) begin
      tmr_d = '0;
    end else if (restart) begin
      tmr_d = TW'(1);
    end else if (at_lim) begin
      tmr_d = tmr_q;
    end else begin
      tmr_d = tmr_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end

  assign due = run && at_lim;

endmodule

// File: rtl/scrub_addr_walker.sv
module scrub_addr_walker
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              reload,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic [ADDR_W-1:0] ptr,
  output logic [PASS_W-1:0] pass_cnt
);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [PASS_W-1:0] cnt_q, cnt_d;
  logic              ptr_en;
  logic              wrap;

  assign wrap   = (ptr_q == hi);
  assign ptr_en = step || reload;

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (step) begin
      if (wrap) begin
        ptr_d = lo;
        cnt_d = cnt_q + PASS_W'(1);
      end else begin
        ptr_d = ptr_q + ADDR_W'(1);
      end
    end else if (reload) begin
      ptr_d = lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_d;
    end
  end

  assign ptr      = ptr_q;
  assign pass_cnt = cnt_q;

endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer
  import scrub_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FAST_IV = 256,
  parameter int SLOW_IV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] range_lo,
  input  logic [ADDR_W-1:0] range_hi,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              cmpl_ack
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  scrub_st_e         st_q, st_d;
  logic              run, fast, due;
  logic              accept, step, reload;
  logic [PASS_W-1:0] pass_cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  scrub_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .pass_cnt (pass_cnt),
    .rd_data  (cfg_rdata),
    .run      (run),
    .fast     (fast)
  );

  scrub_pace_timer #(
    .FAST_IV (FAST_IV),
    .SLOW_IV (SLOW_IV)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run),
    .fast    (fast),
    .restart (accept),
    .due     (due)
  );

  scrub_addr_walker #(
    .ADDR_W (ADDR_W)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (step),
    .reload   (reload),
    .lo       (range_lo),
    .hi       (range_hi),
    .ptr      (req_addr),
    .pass_cnt (pass_cnt)
  );

  assign accept = (st_q == ST_REQ) && req_ready;
  assign step   = (st_q == ST_WAIT) && cmpl_ack;
  assign reload = (st_q == ST_IDLE) && !run;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (run && due) st_d = ST_REQ;
      ST_REQ:  if (req_ready)  st_d = ST_WAIT;
      ST_WAIT: if (cmpl_ack)   st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign req_valid = (st_q == ST_REQ);

endmodule

// File: rtl/scrub_pacer_chk.sv
module scrub_pacer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cfg_rdata,
  input logic [ADDR_W-1:0] range_lo,
  input logic [ADDR_W-1:0] range_hi,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              cmpl_ack
);

  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      out_q <= 1'b1;
    end else if (cmpl_ack) begin
      out_q <= 1'b0;
    end
  end

  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !req_valid);

  // R7
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr >= range_lo) && (req_addr <= range_hi));

  // R8
  cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpl_ack |=> $stable(cfg_rdata[6:5]));

  // R8
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q && cmpl_ack && (req_addr == range_hi) |=>
      cfg_rdata[6:5] == 2'($past(cfg_rdata[6:5]) + 2'd1));

  // R3
  no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1:0] != 2'b10) && !req_valid && !out_q |=> !req_valid);

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:7] == '0 && !cfg_rdata[4]);

endmodule

bind scrub_pacer scrub_pacer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .range_lo  (range_lo),
  .range_hi  (range_hi),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .cmpl_ack  (cmpl_ack)
);

// File: tb/scrub_pacer_bench.sv
`timescale 1ns/1ps
module scrub_pacer_bench;

  localparam int AW   = 16;
  localparam int FIV  = 8;
  localparam int SIV  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic [AW-1:0] range_lo = '0;
  logic [AW-1:0] range_hi = '0;
  logic          req_valid;
  logic          req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic          cmpl_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_ref = 0;
  int hs_count = 0;
  int ack_dly = 2;
  int stall_left = 0;
  int exp_addr_q[$];
  int exp_gap_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scrub_pacer #(.ADDR_W(AW), .FAST_IV(FIV), .SLOW_IV(SIV)) u_scrub_pacer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .range_lo(range_lo), .range_hi(range_hi),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .cmpl_ack(cmpl_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares every handshake with the scoreboard, returns completions
  task automatic handshake();
    int ea, eg;
    if (exp_addr_q.size() == 0) begin
      check(1'b0, "R3 R10 unexpected request", int'(req_addr), -1);
    end else begin
      ea = exp_addr_q.pop_front();
      eg = exp_gap_q.pop_front();
      check(int'(req_addr) == ea, "R7 line address", int'(req_addr), ea);
      check(cyc - last_ref == eg, "R4 R5 R6 request gap", cyc - last_ref, eg);
    end
    last_ref = cyc;
    hs_count++;
    repeat (ack_dly) @(negedge clk);
    cmpl_ack = 1'b1;
    @(negedge clk);
    cmpl_ack = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        if (!req_ready) begin
          check(int'(req_addr) == exp_addr_q[0], "R9 address held in stall",
                int'(req_addr), exp_addr_q[0]);
          stall_left--;
          if (stall_left <= 0) begin
            req_ready = 1'b1;
            handshake();
          end
        end else begin
          handshake();
        end
      end
    end
  end

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    last_ref = cyc + 1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int a, input int g);
    exp_addr_q.push_back(a);
    exp_gap_q.push_back(g);
  endtask

  // runs one pass set: enable, wait for n handshakes, disable, settle
  task automatic run_phase(input int lo, input int hi, input logic [15:0] word,
                           input int n, input int iv, input int k);
    int a;
    int start;
    range_lo = AW'(lo);
    range_hi = AW'(hi);
    ack_dly = k;
    a = lo;
    for (int i = 0; i < n; i++) begin
      push(a, (i == 0) ? iv : ((k + 2 > iv) ? k + 2 : iv));
      a = (a == hi) ? lo : a + 1;
    end
    start = hs_count;
    cfg_write(word);
    wait (hs_count == start + n);
    cfg_write(16'h0000);
    repeat (k + 4) @(negedge clk);
    check(exp_addr_q.size() == 0, "R7 all expected lines issued", exp_addr_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hs0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(cfg_rdata == 16'h0000, "R1 reset control word", cfg_rdata, 0);
    check(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);

    // R2 R3: status bits ignored on write, non-run codes stay idle
    range_lo = 16'h0010; range_hi = 16'h0013;
    hs0 = hs_count;
    cfg_write(16'hFF61);
    check(cfg_rdata == 16'h0001, "R2 read-only bits ignored", cfg_rdata, 16'h0001);
    repeat (3 * SIV) @(negedge clk);
    check(hs_count == hs0 && !req_valid, "R3 enable 01 idle", hs_count - hs0, 0);
    cfg_write(16'h0003);
    check(cfg_rdata == 16'h0003, "R2 field read-back", cfg_rdata, 16'h0003);
    repeat (3 * SIV) @(negedge clk);
    check(hs_count == hs0 && !req_valid, "R3 enable 11 idle", hs_count - hs0, 0);
    cfg_write(16'h000C);
    check(cfg_rdata == 16'h000C, "R2 pace read-back", cfg_rdata, 16'h000C);
    repeat (2 * SIV) @(negedge clk);
    check(hs_count == hs0, "R3 enable 00 idle", hs_count - hs0, 0);

    // R4 R7 R8: fast pace, two passes over four lines
    run_phase(16'h10, 16'h13, 16'h0006, 8, FIV, 2);
    check(cfg_rdata == 16'h0040, "R8 pass count after two passes", cfg_rdata, 16'h0040);

    // R4: normal pace code 10
    run_phase(16'h40, 16'h42, 16'h000A, 3, SIV, 2);
    check(cfg_rdata == 16'h0060, "R8 pass count three", cfg_rdata, 16'h0060);

    // R4: pace code 00 falls back to normal; R10 partial pass then restart
    run_phase(16'h40, 16'h42, 16'h0002, 2, SIV, 2);
    check(cfg_rdata == 16'h0060, "R8 no count on partial pass", cfg_rdata, 16'h0060);
    run_phase(16'h40, 16'h42, 16'h000E, 1, SIV, 2);
    check(cfg_rdata == 16'h0060, "R4 code 11 normal, count held", cfg_rdata, 16'h0060);

    // R6 R8: late completions, single-line range, count wraps
    run_phase(16'h20, 16'h20, 16'h0006, 5, FIV, FIV + 6);
    check(cfg_rdata == 16'h0000, "R8 pass count wraps mod 4", cfg_rdata, 16'h0000);

    // R10: disable while outstanding, then restart with a stall (R9)
    range_lo = 16'h30; range_hi = 16'h37; ack_dly = 2;
    push(16'h30, FIV); push(16'h31, FIV); push(16'h32, FIV);
    hs0 = hs_count;
    cfg_write(16'h0006);
    wait (hs_count == hs0 + 3);
    cfg_write(16'h0000);
    repeat (6 * FIV) @(negedge clk);
    check(hs_count == hs0 + 3 && !req_valid, "R10 no request after disable",
          hs_count - hs0, 3);
    req_ready = 1'b0;
    stall_left = 3;
    push(16'h30, FIV + 2); push(16'h31, FIV);
    hs0 = hs_count;
    cfg_write(16'h0006);
    wait (hs_count == hs0 + 2);
    cfg_write(16'h0000);
    repeat (8) @(negedge clk);
    check(exp_addr_q.size() == 0, "R10 restart from range start", exp_addr_q.size(), 0);
    check(cfg_rdata == 16'h0000, "R8 count unchanged mid-pass", cfg_rdata, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule